// File: doc/BRIEF.md
# Time-of-Day Event Counter with Alarm

This block keeps a 24-bit running count of pulses on an external tick input, such as a once-per-frame or once-per-line sync strobe. Software reaches it through a byte-wide register port. It can read the three count bytes, preload the count or program an alarm value, manage an interrupt mask, and poll or acknowledge the interrupt status. An active-low interrupt line reports a pending alarm whose mask bit is set.

Two access rules keep multi-byte values coherent.

- **Reads:** a read of the most significant byte captures the whole count. Later reads return that snapshot until the least significant byte has been read.
- **Writes:** a write to the most significant count byte stops counting. A write to the least significant byte starts it again, so a preload never straddles a tick.

A control bit redirects byte writes from the count to the alarm. The alarm is compared with the count whenever either one changes.

Register map (bus address):

| Address | Read | Write |
|---|---|---|
| 0 | count bits 7:0 | count or alarm bits 7:0 |
| 1 | count bits 15:8 | count or alarm bits 15:8 |
| 2 | count bits 23:16 | count or alarm bits 23:16 |
| 3 | bit 0 = write target | bit 0 = write target |
| 4 | interrupt status | interrupt mask |

- **Write target (address 3, bit 0):** 0 sends writes to the count, 1 sends them to the alarm.
- **Interrupt status read (address 4):** bit 0 is the alarm flag and bit 7 is the "enabled and pending" summary.
- **Interrupt mask write (address 4):** bit 7 chooses set (1) or clear (0), applied to the mask bits selected by bit 0.

Top module: `tod_alarm_unit`

## Requirements
- R1: After synchronous reset the count and the alarm are 0x000000 and counting is enabled. The mask, the alarm flag and the write target (address 3, bit 0) are 0, and irq_n_o is high. Reset alone never raises the flag.
- R2: While counting is enabled, each cycle with tod_tick_i high adds one to the count, wrapping from 0xFFFFFF to 0x000000. A count write in the same cycle takes priority over the tick.
- R3: A write to address 2 with target 0 stops counting, and ticks are then ignored. A write to address 0 with target 0 loads that byte and resumes counting.
- R4: A byte write to addresses 0 to 2 loads the selected byte of the count when the target bit is 0 and of the alarm when it is 1. Alarm writes leave the count and its run state untouched.
- R5: A read of address 2 captures the full count when no snapshot is held. Reads of addresses 0 to 2 then return the snapshot, and a further read of address 2 does not refresh it. A read of address 0 returns the snapshot byte and releases it.
- R6: With no snapshot held, reads of addresses 0 to 2 return the live count byte.
- R7: When a tick or a write changes the count or the alarm, and the new values are equal, status bit 0 becomes 1 in the following cycle.
- R8: A write to address 4 with bit 7 = 1 sets the mask bit selected by bit 0; with bit 7 = 0 it clears that bit. A flag that is pending while masked leaves irq_n_o high.
- R9: A read of address 4 returns bit 0 = flag and bit 7 = (flag AND mask), with bits 6:1 zero. It clears the flag.
- R10: irq_n_o is low exactly when the alarm flag and its mask bit are both 1.
- R11: An alarm match in the same cycle as a status read is not lost: the read returns the old status and the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tod_tick_i | input | 1 | One-cycle count strobe |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current address |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The count is driven by the following patterns:

- **Sparse ticks from reset:** show plain incrementing.
- **Preload ending two below the wrap point:** the ticks sent while halted distinguish a stopped count from a running one, and the following ticks expose the wrap to zero.
- **Snapshot reads with ticks between them:** separate frozen bytes from live bytes, including a repeated high-byte read that must not refresh the snapshot.
- **Alarm reached by counting, by a count write under a cleared mask, and in the same cycle as a status read:** distinguish flag setting, masking and acknowledge priority.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int TOD_WIDTH   = 24;
    localparam int STAT_ANY_IX = 7;

    typedef enum logic {
        TGT_COUNT = 1'b0,
        TGT_ALARM = 1'b1
    } wr_target_e;

    typedef struct packed {
        logic       any;
        logic [6:0] flags;
    } irq_status_t;

    function automatic logic [7:0] status_byte(irq_status_t s);
        return {s.any, s.flags};
    endfunction

endpackage

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int WIDTH = TOD_WIDTH,
    parameter int AW    = 3,
    localparam int BYTES = WIDTH / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [7:0]       wr_data,
    input  wr_target_e       target,
    output logic [WIDTH-1:0] count_o,
    output logic [WIDTH-1:0] alarm_o,
    output logic             run_o,
    output logic             match_o
);

    logic [WIDTH-1:0] cnt_q, cnt_d, alm_q, alm_d;
    logic             run_q, run_d;
    logic [BYTES-1:0] lane_we;
    logic             cnt_write, changed;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lane_we[g] = wr_en && (wr_addr == AW'(g));
    end

    assign cnt_write = (|lane_we) && (target == TGT_COUNT);

    always_comb begin
        cnt_d   = cnt_q;
        alm_d   = alm_q;
        run_d   = run_q;
        changed = 1'b0;
        for (int b = 0; b < BYTES; b++) begin
            if (lane_we[b]) begin
                changed = 1'b1;
                if (target == TGT_ALARM) begin
                    alm_d[b*8 +: 8] = wr_data;
                end else begin
                    cnt_d[b*8 +: 8] = wr_data;
                    if (b == BYTES - 1) run_d = 1'b0;
                    if (b == 0)         run_d = 1'b1;
                end
            end
        end
        if (!cnt_write && tick && run_q) begin
            cnt_d   = cnt_q + 1'b1;
            changed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            alm_q <= '0;
            run_q <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            alm_q <= alm_d;
            run_q <= run_d;
        end
    end

    assign match_o = changed && (cnt_d == alm_d);
    assign count_o = cnt_q;
    assign alarm_o = alm_q;
    assign run_o   = run_q;

endmodule

// File: rtl/tod_read_latch.sv
module tod_read_latch #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] count,
    input  logic             rd_high,
    input  logic             rd_low,
    output logic [WIDTH-1:0] view_o,
    output logic             hold_o
);

    logic [WIDTH-1:0] snap_q;
    logic             hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            hold_q <= 1'b0;
        end else if (rd_low) begin
            hold_q <= 1'b0;
        end else if (rd_high && !hold_q) begin
            snap_q <= count;
            hold_q <= 1'b1;
        end
    end

    assign view_o = hold_q ? snap_q : count;
    assign hold_o = hold_q;

endmodule

// File: rtl/tod_irq_ctrl.sv
module tod_irq_ctrl
    import tod_pkg::*;
#(
    parameter int SRC_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src_evt,
    input  logic             mask_wr,
    input  logic             mask_set,
    input  logic [SRC_W-1:0] mask_sel,
    input  logic             status_rd,
    output logic [SRC_W-1:0] flags_o,
    output logic [SRC_W-1:0] mask_o,
    output logic [7:0]       status_o,
    output logic             irq_n_o
);

    logic [SRC_W-1:0] flag_q, mask_q;
    irq_status_t      stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            mask_q <= '0;
        end else begin
            flag_q <= (status_rd ? '0 : flag_q) | src_evt;
            if (mask_wr) begin
                mask_q <= mask_set ? (mask_q | mask_sel) : (mask_q & ~mask_sel);
            end
        end
    end

    always_comb begin
        stat              = '0;
        stat.flags[SRC_W-1:0] = flag_q;
        stat.any          = |(flag_q & mask_q);
    end

    assign status_o = status_byte(stat);
    assign irq_n_o  = ~stat.any;
    assign flags_o  = flag_q;
    assign mask_o   = mask_q;

endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
    import tod_pkg::*;
#(
    parameter int WIDTH = TOD_WIDTH,
    localparam int BYTES = WIDTH / 8,
    localparam int AW    = $clog2(BYTES + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tod_tick_i,
    input  logic          bus_sel_i,
    input  logic          bus_wr_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [7:0]    bus_wdata_i,
    output logic [7:0]    bus_rdata_o,
    output logic          irq_n_o
);

    localparam logic [AW-1:0] A_LOW  = AW'(0);
    localparam logic [AW-1:0] A_HIGH = AW'(BYTES - 1);
    localparam logic [AW-1:0] A_CTRL = AW'(BYTES);
    localparam logic [AW-1:0] A_IRQ  = AW'(BYTES + 1);

    logic             acc_wr, acc_rd;
    wr_target_e       target_q;
    logic [WIDTH-1:0] count_w, alarm_w, view_w;
    logic             run_w, hold_w, match_w;
    logic [0:0]       flag_w, mask_w;
    logic [7:0]       status_w;

    assign acc_wr = bus_sel_i && bus_wr_i;
    assign acc_rd = bus_sel_i && !bus_wr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= TGT_COUNT;
        end else if (acc_wr && bus_addr_i == A_CTRL) begin
            target_q <= wr_target_e'(bus_wdata_i[0]);
        end
    end

    tod_counter #(.WIDTH(WIDTH), .AW(AW)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .tick    (tod_tick_i),
        .wr_en   (acc_wr),
        .wr_addr (bus_addr_i),
        .wr_data (bus_wdata_i),
        .target  (target_q),
        .count_o (count_w),
        .alarm_o (alarm_w),
        .run_o   (run_w),
        .match_o (match_w)
    );

    tod_read_latch #(.WIDTH(WIDTH)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .count   (count_w),
        .rd_high (acc_rd && bus_addr_i == A_HIGH),
        .rd_low  (acc_rd && bus_addr_i == A_LOW),
        .view_o  (view_w),
        .hold_o  (hold_w)
    );

    tod_irq_ctrl #(.SRC_W(1)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .src_evt   (match_w),
        .mask_wr   (acc_wr && bus_addr_i == A_IRQ),
        .mask_set  (bus_wdata_i[STAT_ANY_IX]),
        .mask_sel  (bus_wdata_i[0]),
        .status_rd (acc_rd && bus_addr_i == A_IRQ),
        .flags_o   (flag_w),
        .mask_o    (mask_w),
        .status_o  (status_w),
        .irq_n_o   (irq_n_o)
    );

    always_comb begin
        bus_rdata_o = 8'h00;
        for (int b = 0; b < BYTES; b++) begin
            if (bus_addr_i == AW'(b)) bus_rdata_o = view_w[b*8 +: 8];
        end
        if (bus_addr_i == A_CTRL) bus_rdata_o = {7'b0, target_q == TGT_ALARM};
        if (bus_addr_i == A_IRQ)  bus_rdata_o = status_w;
    end

endmodule

// File: rtl/tod_alarm_unit_chk.sv
module tod_alarm_unit_chk #(
    parameter int WIDTH = 24,
    parameter int AW    = 3,
    localparam int BYTES = WIDTH / 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             sel,
    input logic             wr,
    input logic [AW-1:0]    addr,
    input logic             wd_dir,
    input logic             wd_b0,
    input logic             irq_n,
    input logic [WIDTH-1:0] cnt,
    input logic             run,
    input logic             tgt_alarm,
    input logic             hold,
    input logic [WIDTH-1:0] view,
    input logic             flag,
    input logic             mask,
    input logic             alarm_evt
);

    logic byte_wr, cnt_wr, alm_wr, rd_low, stat_rd, mask_on;

    assign byte_wr = sel && wr && (addr < AW'(BYTES));
    assign cnt_wr  = byte_wr && !tgt_alarm;
    assign alm_wr  = byte_wr && tgt_alarm;
    assign rd_low  = sel && !wr && (addr == AW'(0));
    assign stat_rd = sel && !wr && (addr == AW'(BYTES + 1));
    assign mask_on = sel && wr && (addr == AW'(BYTES + 1)) && wd_dir && wd_b0;

    AST_RESET_IRQ_IDLE: assert property (@(posedge clk)
        rst |=> irq_n); // R1

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !cnt_wr) |=> (cnt == WIDTH'($past(cnt) + 1'b1))); // R2

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt)); // R3

    AST_ALARM_WRITE_SIDE: assert property (@(posedge clk) disable iff (rst)
        (alm_wr && !(tick && run)) |=> ($stable(cnt) && run == $past(run))); // R4

    AST_SNAPSHOT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (hold && !rd_low) |=> $stable(view)); // R5

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        mask_on |=> mask); // R8

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !alarm_evt) |=> !flag); // R9

    AST_ACK_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && alarm_evt) |=> flag); // R11

endmodule

bind tod_alarm_unit tod_alarm_unit_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tod_tick_i),
    .sel       (bus_sel_i),
    .wr        (bus_wr_i),
    .addr      (bus_addr_i),
    .wd_dir    (bus_wdata_i[7]),
    .wd_b0     (bus_wdata_i[0]),
    .irq_n     (irq_n_o),
    .cnt       (count_w),
    .run       (run_w),
    .tgt_alarm (target_q == tod_pkg::TGT_ALARM),
    .hold      (hold_w),
    .view      (view_w),
    .flag      (flag_w[0]),
    .mask      (mask_w[0]),
    .alarm_evt (match_w)
);

// File: tb/tod_alarm_unit_bench.sv
module tod_alarm_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_n;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    tod_alarm_unit u_tod_alarm_unit (
        .clk         (clk),
        .rst         (rst),
        .tod_tick_i  (tick),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_n_o     (irq_n)
    );

    // behavioural reference state
    logic [23:0] m_cnt, m_alarm, m_lat, old_cnt, nc, na;
    bit          m_run, m_hold, m_asel, m_mask, m_flag, upd, cw;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_alarm = 0; m_lat = 0; m_run = 1; m_hold = 0;
            m_asel = 0; m_mask = 0; m_flag = 0;
        end else begin
            old_cnt = m_cnt; nc = m_cnt; na = m_alarm; upd = 0;
            cw = sel && wr && addr <= 2 && !m_asel;
            if (sel && wr && addr <= 2) begin
                upd = 1;
                if (m_asel) na[addr*8 +: 8] = wdata;
                else begin
                    nc[addr*8 +: 8] = wdata;
                    if (addr == 2) m_run = 0;
                    if (addr == 0) m_run = 1;
                end
            end
            if (!cw && tick && m_run && !(sel && wr && addr == 0)) begin
                nc = nc + 1; upd = 1;
            end
            if (sel && wr && addr == 3) m_asel = wdata[0];
            if (sel && wr && addr == 4) m_mask = wdata[7] ? (m_mask | wdata[0]) : (m_mask & !wdata[0]);
            if (sel && !wr) begin
                if (addr == 2 && !m_hold) begin m_lat = old_cnt; m_hold = 1; end
                else if (addr == 0) m_hold = 0;
                if (addr == 4) m_flag = 0;
            end
            if (upd && nc == na) m_flag = 1;
            m_cnt = nc; m_alarm = na;
        end
    end

    function automatic logic [7:0] model_rdata();
        logic [23:0] src;
        src = m_hold ? m_lat : m_cnt;
        case (addr)
            3'd0, 3'd1, 3'd2: return src[addr*8 +: 8];
            3'd3:             return {7'b0, m_asel};
            3'd4:             return {m_flag & m_mask, 6'b0, m_flag};
            default:          return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference, away from the edge
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            check(cur_req, {7'b0, irq_n}, {7'b0, !(m_flag && m_mask)});
            if (sel && !wr) check(cur_req, rdata, model_rdata());
        end
    end

    task automatic cyc(input bit s, input bit w, input logic [2:0] a, input logic [7:0] d, input bit t);
        @(negedge clk);
        sel = s; wr = w; addr = a; wdata = d; tick = t;
    endtask

    task automatic idle();
        cyc(0, 0, 3'd0, 8'h00, 0);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        cyc(1, 1, a, d, 0);
    endtask

    task automatic rexp(input logic [2:0] a, input logic [7:0] exp, input string req);
        cyc(1, 0, a, 8'h00, 0);
        #1 check(req, rdata, exp);
    endtask

    task automatic irq_exp(input bit exp, input string req);
        idle();
        #1 check(req, {7'b0, irq_n}, {7'b0, exp});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(0, 0, 3'd0, 8'h00, 1);
            idle();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        rexp(3'd0, 8'h00, "R1");
        rexp(3'd4, 8'h00, "R1");
        rexp(3'd3, 8'h00, "R1");
        irq_exp(1'b1, "R1");

        cur_req = "R2";
        ticks(10);
        rexp(3'd2, 8'h00, "R2");
        rexp(3'd1, 8'h00, "R2");
        rexp(3'd0, 8'h0A, "R2");

        cur_req = "R3";
        wreg(3'd2, 8'hFF);
        ticks(3);
        wreg(3'd1, 8'hFF);
        ticks(1);
        wreg(3'd0, 8'hFE);
        rexp(3'd2, 8'hFF, "R3");
        rexp(3'd1, 8'hFF, "R3");
        rexp(3'd0, 8'hFE, "R3");
        cur_req = "R2";
        ticks(3);
        rexp(3'd2, 8'h00, "R2");
        rexp(3'd1, 8'h00, "R2");
        rexp(3'd0, 8'h01, "R2");
        cur_req = "R7";
        rexp(3'd4, 8'h01, "R7");
        rexp(3'd4, 8'h00, "R9");

        cur_req = "R5";
        rexp(3'd2, 8'h00, "R5");
        ticks(5);
        rexp(3'd2, 8'h00, "R5");
        rexp(3'd1, 8'h00, "R5");
        rexp(3'd0, 8'h01, "R5");
        rexp(3'd0, 8'h06, "R6");

        cur_req = "R4";
        wreg(3'd3, 8'h01);
        rexp(3'd3, 8'h01, "R4");
        wreg(3'd2, 8'h00);
        wreg(3'd1, 8'h00);
        wreg(3'd0, 8'h0A);
        ticks(1);
        wreg(3'd3, 8'h00);
        rexp(3'd0, 8'h07, "R4");

        cur_req = "R10";
        wreg(3'd4, 8'h81);
        rexp(3'd4, 8'h00, "R8");
        ticks(3);
        irq_exp(1'b0, "R10");
        rexp(3'd4, 8'h81, "R9");
        irq_exp(1'b1, "R10");
        rexp(3'd4, 8'h00, "R9");

        cur_req = "R8";
        wreg(3'd4, 8'h01);
        wreg(3'd2, 8'h00);
        wreg(3'd1, 8'h00);
        wreg(3'd0, 8'h09);
        irq_exp(1'b1, "R8");
        rexp(3'd4, 8'h01, "R8");
        rexp(3'd4, 8'h00, "R9");

        cur_req = "R11";
        wreg(3'd4, 8'h81);
        cyc(1, 0, 3'd4, 8'h00, 1);
        #1 check("R11", rdata, 8'h00);
        irq_exp(1'b0, "R11");
        rexp(3'd4, 8'h81, "R11");
        idle();
        idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule